// File: doc/BRIEF.md
# Transfer-Level Round-Robin Channel Arbiter

This block decides which of four direct-memory-access channels is served next. Each channel may raise a request, and the request is held in a pending flag until the channel is granted. Only one channel holds the grant at a time. The grant stays in place until the transfer engine pulses its transfer-done strobe. A running transfer is never taken away from its channel.

The priority order is cyclic. It is stored as the index of the channel that currently ranks first. The other channels follow it in increasing number, wrapping modulo the channel count. The order changes only when a granted transfer completes. The channel that just finished then drops to last place, and the channel numbered one above it becomes first. This rotation depends only on which channel finished. Channels that were skipped over also move down with it.

The order index is available as an output, so the engine or a neighbouring block can see the ranking in force. After every completed transfer the grant is low for at least one cycle before the next channel is granted.

Top module: `rr_xfer_arb`

## Requirements
- R1: While reset is high and on the first cycle after it, `gnt_o` is all zeros, `gnt_vld_o` is 0 and `head_o` is 0, which means the order 0 > 1 > 2 > 3.
- R2: `gnt_o` has at most one bit set, and `gnt_vld_o` is 1 exactly when one bit of `gnt_o` is set. Bit k of `gnt_o` stands for channel k.
- R3: When several channels are pending at the moment a grant is issued, the grant goes to the first pending channel in the sequence `head_o`, `head_o`+1, … taken modulo 4. The other channels stay pending.
- R4: A request held high for a single cycle on `req_i[k]` is remembered and is served later, even if it arrives while another channel holds the grant.
- R5: Once a grant is issued, `gnt_o` and `gnt_vld_o` stay unchanged until a cycle in which `done_i` is high. New requests do not disturb the grant.
- R6: `done_i` sampled high while channel k holds the grant sets `head_o` to (k+1) mod 4 on that edge. This puts channel k last. `head_o` changes at no other time.
- R7: The edge that samples `done_i` during a grant drops the grant. If anything is pending, the next grant appears on the following edge, so the grant is low for exactly one cycle.
- R8: `done_i` sampled high while no grant is active is ignored. `head_o` keeps its value and no grant results from it.
- R9: When no grant is active, a request sampled at one edge becomes a grant at the next edge. `gnt_vld_o` stays 0 while nothing is pending.
- R10: Starting from reset, suppose channels 0 and 3 request together and channel 1 requests during channel 0's transfer. The channels are then served in the order 0, 1, 3, and `head_o` ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | NUM_CH | Per-channel transfer request; bit k is channel k |
| done_i | input | 1 | Transfer-done strobe from the engine |
| gnt_o | output | NUM_CH | One-hot grant; bit k is channel k |
| gnt_vld_o | output | 1 | A grant is active |
| head_o | output | IDX_W | Index of the highest-priority channel |

## Verification
The hardest situation to reach is a pending set that is resolved while `head_o` is not zero. Only then does the wrap-around in the priority scan matter, for example when channel 3 must beat channel 0. To get there, the bench first completes a transfer on a chosen channel to move the head. It then injects requests that straddle the wrap point. The bench also sends request pulses in the middle of a transfer and a done strobe while idle. These steps show that requests are latched and not dropped, that a running grant is not preempted, and that a stray strobe does not rotate the order.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } arb_st_e;
endpackage

// File: rtl/rr_arb_pend.sv
// Per-channel pending flags: set by a request, cleared when the grant starts.
module rr_arb_pend #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] clr_i,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] pend_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst)           pend_q[g] <= 1'b0;
      else if (clr_i[g]) pend_q[g] <= 1'b0;
      else if (req_i[g]) pend_q[g] <= 1'b1;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/rr_arb_pick.sv
// Scans pending channels starting at the head index, wrapping modulo NUM_CH.
module rr_arb_pick #(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic [NUM_CH-1:0] pend_i,
  input  logic [IDX_W-1:0]  head_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  sel_o,
  output logic [NUM_CH-1:0] sel_oh_o
);
  always_comb begin
    found_o = 1'b0;
    sel_o   = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      int idx;
      idx = (int'(head_i) + k) % NUM_CH;
      if (!found_o && pend_i[idx]) begin
        found_o = 1'b1;
        sel_o   = IDX_W'(idx);
      end
    end
  end

  always_comb begin
    sel_oh_o = '0;
    if (found_o) sel_oh_o[sel_o] = 1'b1;
  end
endmodule

// File: rtl/rr_arb_ctrl.sv
// Grant state, grant register and rotating head index.
module rr_arb_ctrl
  import rr_arb_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic              found_i,
  input  logic [IDX_W-1:0]  sel_i,
  input  logic [NUM_CH-1:0] sel_oh_i,
  output logic [NUM_CH-1:0] clr_o,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              gnt_vld_o,
  output logic [IDX_W-1:0]  head_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CH - 1);

  arb_st_e           st_q;
  logic [IDX_W-1:0]  own_q;
  logic [IDX_W-1:0]  head_q;
  logic [NUM_CH-1:0] gnt_q;
  logic              vld_q;
  logic              start;

  assign start = (st_q == ST_IDLE) && found_i;
  assign clr_o = start ? sel_oh_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      own_q  <= '0;
      head_q <= '0;
      gnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (found_i) begin
            st_q  <= ST_BUSY;
            own_q <= sel_i;
            gnt_q <= sel_oh_i;
            vld_q <= 1'b1;
          end
        end
        ST_BUSY: begin
          if (done_i) begin
            st_q   <= ST_IDLE;
            gnt_q  <= '0;
            vld_q  <= 1'b0;
            head_q <= (own_q == LAST) ? '0 : own_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign gnt_o     = gnt_q;
  assign gnt_vld_o = vld_q;
  assign head_o    = head_q;
endmodule

// File: rtl/rr_xfer_arb.sv
module rr_xfer_arb #(
  parameter int NUM_CH = 4,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              done_i,
  output logic [NUM_CH-1:0] gnt_o,
  output logic              gnt_vld_o,
  output logic [IDX_W-1:0]  head_o
);
  logic [NUM_CH-1:0] pend;
  logic [NUM_CH-1:0] clr;
  logic [NUM_CH-1:0] sel_oh;
  logic [IDX_W-1:0]  sel;
  logic              found;

  rr_arb_pend #(.NUM_CH(NUM_CH)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  rr_arb_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
    .pend_i   (pend),
    .head_i   (head_o),
    .found_o  (found),
    .sel_o    (sel),
    .sel_oh_o (sel_oh)
  );

  rr_arb_ctrl #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .done_i    (done_i),
    .found_i   (found),
    .sel_i     (sel),
    .sel_oh_i  (sel_oh),
    .clr_o     (clr),
    .gnt_o     (gnt_o),
    .gnt_vld_o (gnt_vld_o),
    .head_o    (head_o)
  );
endmodule

// File: rtl/rr_xfer_arb_chk.sv
module rr_xfer_arb_chk #(
  parameter int NUM_CH = 4,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] req_i,
  input logic              done_i,
  input logic [NUM_CH-1:0] gnt_o,
  input logic              gnt_vld_o,
  input logic [IW-1:0]     head_o
);
  function automatic logic [IW-1:0] after_of(input logic [NUM_CH-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_CH; k++)
      if (oh[k]) r = IW'((k + 1) % NUM_CH);
    return r;
  endfunction

  logic unused_req;
  assign unused_req = |req_i;

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o) && (gnt_vld_o == (gnt_o != '0)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld_o && !done_i) |=> (gnt_vld_o && $stable(gnt_o)));

  a_r7_gap: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld_o && done_i) |=> !gnt_vld_o);

  a_r6_rotate: assert property (@(posedge clk) disable iff (rst)
    (gnt_vld_o && done_i) |=> (head_o == after_of($past(gnt_o))));

  a_r6_head_still: assert property (@(posedge clk) disable iff (rst)
    !done_i |=> $stable(head_o));

  a_r8_idle_done: assert property (@(posedge clk) disable iff (rst)
    (!gnt_vld_o && done_i) |=> $stable(head_o));
endmodule

bind rr_xfer_arb rr_xfer_arb_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_i     (req_i),
  .done_i    (done_i),
  .gnt_o     (gnt_o),
  .gnt_vld_o (gnt_vld_o),
  .head_o    (head_o)
);

// File: tb/rr_xfer_arb_tb.sv
`timescale 1ns/1ps
module rr_xfer_arb_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_i = '0;
  logic         done_i = 1'b0;
  logic [N-1:0] gnt_o;
  logic         gnt_vld_o;
  logic [1:0]   head_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rr_xfer_arb #(.NUM_CH(N)) u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .done_i(done_i),
    .gnt_o(gnt_o), .gnt_vld_o(gnt_vld_o), .head_o(head_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_state(string tag, logic [N-1:0] g, logic v, logic [1:0] h);
    checks++;
    if (gnt_o !== g || gnt_vld_o !== v || head_o !== h) begin
      errors++;
      $display("FAIL %s: gnt=%b vld=%b head=%0d, expected gnt=%b vld=%b head=%0d",
               tag, gnt_o, gnt_vld_o, head_o, g, v, h);
    end
  endtask

  task automatic pulse_req(logic [N-1:0] m);
    req_i = m;
    tick();
    req_i = '0;
  endtask

  task automatic finish_xfer();
    done_i = 1'b1;
    tick();
    done_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_i = '0;
    done_i = 1'b0;
    tick();
    tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_state("R1 reset state", 4'b0000, 1'b0, 2'd0);
    tick();
    expect_state("R9 idle with nothing pending", 4'b0000, 1'b0, 2'd0);
  endtask

  task automatic t_single_and_hold();
    pulse_req(4'b0100);
    expect_state("R9 not granted before latch edge", 4'b0000, 1'b0, 2'd0);
    tick();
    expect_state("R4 R9 R2 channel 2 granted", 4'b0100, 1'b1, 2'd0);
    pulse_req(4'b0001);
    tick();
    tick();
    expect_state("R5 grant held while channel 0 waits", 4'b0100, 1'b1, 2'd0);
    finish_xfer();
    expect_state("R6 R7 channel 2 done, head 3, grant dropped", 4'b0000, 1'b0, 2'd3);
    tick();
    expect_state("R7 R4 latched channel 0 granted after gap", 4'b0001, 1'b1, 2'd3);
    finish_xfer();
    expect_state("R6 channel 0 done, head 1", 4'b0000, 1'b0, 2'd1);
  endtask

  task automatic t_idle_done();
    tick();
    finish_xfer();
    expect_state("R8 done while idle keeps head", 4'b0000, 1'b0, 2'd1);
    tick();
    expect_state("R8 no grant from idle done", 4'b0000, 1'b0, 2'd1);
  endtask

  task automatic t_wrap_priority();
    pulse_req(4'b1001);
    tick();
    expect_state("R3 head 1: channel 3 beats channel 0", 4'b1000, 1'b1, 2'd1);
    finish_xfer();
    expect_state("R6 channel 3 done, head wraps to 0", 4'b0000, 1'b0, 2'd0);
    tick();
    expect_state("R3 waiting channel 0 served next", 4'b0001, 1'b1, 2'd0);
    finish_xfer();
    expect_state("R6 head 1 after channel 0", 4'b0000, 1'b0, 2'd1);
  endtask

  task automatic t_sequence();
    do_reset();
    pulse_req(4'b1001);
    tick();
    expect_state("R10 channel 0 first", 4'b0001, 1'b1, 2'd0);
    pulse_req(4'b0010);
    expect_state("R10 R5 channel 0 not preempted", 4'b0001, 1'b1, 2'd0);
    finish_xfer();
    expect_state("R10 order 1>2>3>0", 4'b0000, 1'b0, 2'd1);
    tick();
    expect_state("R10 channel 1 second", 4'b0010, 1'b1, 2'd1);
    finish_xfer();
    expect_state("R10 order 2>3>0>1", 4'b0000, 1'b0, 2'd2);
    tick();
    expect_state("R10 channel 3 third", 4'b1000, 1'b1, 2'd2);
    finish_xfer();
    expect_state("R10 order back to 0>1>2>3", 4'b0000, 1'b0, 2'd0);
    tick();
    expect_state("R10 R9 nothing left pending", 4'b0000, 1'b0, 2'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single_and_hold();
    t_idle_done();
    t_wrap_priority();
    t_sequence();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung, expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule